// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Compare Clear

An up-counting timer for a peripheral set. A prescaler divides the peripheral clock by one of four ratios and sends a one-cycle count pulse. The counter adds one on each pulse while the run bit is set, and wraps from all-ones back to zero. The current count is exported so that capture and compare units can use it. Those units supply a compare value, and when the compare-clear mode is on, the counter restarts from zero where the count meets that value.

Software uses a small synchronous register bus with two words: control and count. A clear request written to the control word stays pending and reads back as 1 until the counter has really been cleared. A clear takes effect only while the timer runs. While the timer is stopped, software zeroes it by writing the count word.

Top module: `frt_timer`

## Requirements
- R1: After reset the count is 0x0000 and every control field reads 0.
- R2: While running, the count advances by 1 every N clock cycles, where N is set by the divider field: 00 gives 4, 01 gives 16, 10 gives 32 and 11 gives 64. The first step comes N cycles after the run bit is written.
- R3: The count wraps from 0xFFFF to 0x0000.
- R4: While stopped, the count and the prescaler hold their values, and neither a clear request nor a compare match changes the count. A write to the count word (address 1) loads the written value.
- R5: Writing 1 to the clear bit (control bit 2) while running zeroes the count on the next clock edge and restarts the prescaler. The bit reads as 1 from the write until that clear, then returns to 0.
- R6: Writing 0 to the clear bit has no effect. A pending request stays pending for as long as the timer is stopped.
- R7: With compare-clear mode on (control bit 1), the count pulse that finds the count equal to the compare input loads 0x0000 instead of advancing.
- R8: With compare-clear mode off, the count passes the compare value without clearing.
- R9: If a write of 1 to the clear bit lands in the same cycle as a clear, the bit stays 1 and is released by the following clear.
- R10: Writing the control word with a divider value different from the current one restarts the prescaler from zero.
- R11: Address 0 is the control word: run in bit 0, compare-clear mode in bit 1, the clear request in bit 2, and the divider in bits 5:4. Address 1 is the count. Read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 count |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the selected register |
| cmp_val_i | input | 16 | Compare value from the output-compare unit |
| count_o | output | 16 | Current count |

## Verification
If the prescaler state is wrong, the first step after a start, a clear or a divider change comes at the wrong cycle. The bench checks the count on both sides of that step, so the error shows at count_o within one division period. If the pending-clear flag is wrong, it shows in control bit 2 one cycle after a clear request or after a coincident clear. A wrong compare decision shows within one count period of the match, because the next value is then the compare value plus one instead of zero.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [1:0] {
    DIV_4  = 2'b00,
    DIV_16 = 2'b01,
    DIV_32 = 2'b10,
    DIV_64 = 2'b11
  } div_sel_e;

  localparam int PRE_W = 6;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CNT  = 1'b1;

  localparam int BIT_RUN  = 0;
  localparam int BIT_MODE = 1;
  localparam int BIT_CLR  = 2;
  localparam int BIT_DIV  = 4;

  function automatic logic [PRE_W-1:0] div_last(input div_sel_e sel);
    case (sel)
      DIV_4:   div_last = PRE_W'(3);
      DIV_16:  div_last = PRE_W'(15);
      DIV_32:  div_last = PRE_W'(31);
      default: div_last = PRE_W'(63);
    endcase
  endfunction
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler
  import frt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     restart_i,
  input  div_sel_e div_sel_i,
  output logic     tick_o
);
  logic [PRE_W-1:0] pre_q;

  assign tick_o = run_i && (pre_q == div_last(div_sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (restart_i || tick_o) pre_q <= '0;
    else if (run_i)              pre_q <= pre_q + 1'b1;
  end

  assert_pre_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(pre_q));

  // shortest ratio is 4, so pulses never touch
  assert_tick_spaced_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             cmp_mode_i,
  input  logic             clr_wr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             clr_pend_o,
  output logic             clear_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             cmp_hit;

  assign cmp_hit = tick_i && cmp_mode_i && (cnt_q == cmp_val_i);
  assign clear_o = run_i && (pend_q || cmp_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_o) cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  // a new request wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (clr_wr_i) pend_q <= 1'b1;
    else if (clear_o)  pend_q <= 1'b0;
  end

  assign cnt_o      = cnt_q;
  assign clr_pend_o = pend_q;

  assert_hold_stopped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));

  assert_pend_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !run_i) |=> pend_q);

  assert_coincide_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && clear_o) |=> (pend_q && cnt_q == '0));

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_o && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/frt_timer.sv
module frt_timer
  import frt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [CNT_W-1:0] cmp_val_i,
  output logic [CNT_W-1:0] count_o
);
  logic     run_q, mode_q;
  div_sel_e div_q;
  logic     ctrl_wr, cnt_wr, div_chg, clr_wr;
  logic     tick, clear, pend;
  div_sel_e div_new;

  assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);
  assign cnt_wr  = we_i && (addr_i == ADDR_CNT);
  assign div_new = div_sel_e'(wdata_i[BIT_DIV +: 2]);
  assign div_chg = ctrl_wr && (div_new != div_q);
  assign clr_wr  = ctrl_wr && wdata_i[BIT_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      div_q  <= DIV_4;
    end else if (ctrl_wr) begin
      run_q  <= wdata_i[BIT_RUN];
      mode_q <= wdata_i[BIT_MODE];
      div_q  <= div_new;
    end
  end

  frt_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .restart_i (div_chg || clear),
    .div_sel_i (div_q),
    .tick_o    (tick)
  );

  frt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .tick_i     (tick),
    .cmp_mode_i (mode_q),
    .clr_wr_i   (clr_wr),
    .load_i     (cnt_wr),
    .load_val_i (wdata_i),
    .cmp_val_i  (cmp_val_i),
    .cnt_o      (count_o),
    .clr_pend_o (pend),
    .clear_o    (clear)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CNT) begin
      rdata_o = count_o;
    end else begin
      rdata_o[BIT_RUN]      = run_q;
      rdata_o[BIT_MODE]     = mode_q;
      rdata_o[BIT_CLR]      = pend;
      rdata_o[BIT_DIV +: 2] = div_q;
    end
  end

  assert_stopped_no_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !clear);
endmodule

// File: tb/frt_timer_tb.sv
module frt_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic        addr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [15:0] cmp_val_i = '0;
  logic [15:0] count_o;

  int n_chk = 0;
  int n_bad = 0;

  frt_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cmp_val_i(cmp_val_i), .count_o(count_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [15:0] ctl(input logic run, input logic mode,
                                      input logic clr, input logic [1:0] div);
    return {10'b0, div, 1'b0, clr, mode, run};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; we_i = 1'b0; addr_i = 1'b0; wdata_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // one write edge, returns at the following negedge
  task automatic wr(input logic a, input logic [15:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(1'b0, v); chk("R1 ctrl", v, 16'h0000);
    rd(1'b1, v); chk("R1 count", v, 16'h0000);
    chk("R1 count_o", count_o, 16'h0000);
  endtask

  task automatic t_div(input logic [1:0] sel, input int n);
    do_reset();
    wr(1'b0, ctl(1'b1, 1'b0, 1'b0, sel));
    wait_edges(n - 1); chk("R2 before step", count_o, 16'h0000);
    wait_edges(1);     chk("R2 first step", count_o, 16'h0001);
    wait_edges(n);     chk("R2 second step", count_o, 16'h0002);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    do_reset();
    wr(1'b1, 16'hFFFE);
    rd(1'b1, v); chk("R11 count read", v, 16'hFFFE);
    wr(1'b0, ctl(1'b1, 1'b0, 1'b0, 2'b00));
    wait_edges(4); chk("R3 at max", count_o, 16'hFFFF);
    wait_edges(4); chk("R3 wrapped", count_o, 16'h0000);
  endtask

  task automatic t_stopped();
    logic [15:0] v;
    do_reset();
    cmp_val_i = 16'h1234;
    wr(1'b1, 16'h1234);
    chk("R4 load", count_o, 16'h1234);
    wr(1'b0, ctl(1'b0, 1'b1, 1'b1, 2'b00));
    wait_edges(20);
    chk("R4 held", count_o, 16'h1234);
    rd(1'b0, v); chk("R11 ctrl pend read", v, 16'h0006);
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 2'b00));
    rd(1'b0, v); chk("R6 clr write 0 ignored", v[2], 1'b1);
    wr(1'b1, 16'h0000);
    chk("R4 zero by data write", count_o, 16'h0000);
    wr(1'b1, 16'h00A0);
    wr(1'b0, ctl(1'b1, 1'b0, 1'b0, 2'b00));
    rd(1'b0, v); chk("R6 still pending at start", v[2], 1'b1);
    wait_edges(1);
    rd(1'b0, v); chk("R5 released once running", v[2], 1'b0);
    chk("R5 cleared once running", count_o, 16'h0000);
    cmp_val_i = 16'h0000;
  endtask

  task automatic t_clear_run();
    logic [15:0] v;
    do_reset();
    wr(1'b0, ctl(1'b1, 1'b0, 1'b0, 2'b00));
    wait_edges(9);
    chk("R2 count before clear", count_o, 16'h0002);
    wr(1'b0, ctl(1'b1, 1'b0, 1'b1, 2'b00));
    rd(1'b0, v); chk("R5 reads 1 pending", v[2], 1'b1);
    chk("R5 count not yet cleared", count_o, 16'h0002);
    wait_edges(1);
    rd(1'b0, v); chk("R5 self release", v[2], 1'b0);
    chk("R5 cleared", count_o, 16'h0000);
    wait_edges(3); chk("R5 prescaler restarted", count_o, 16'h0000);
    wait_edges(1); chk("R5 first step after clear", count_o, 16'h0001);
  endtask

  task automatic t_compare(input logic mode);
    logic [15:0] v;
    do_reset();
    cmp_val_i = 16'h0002;
    wr(1'b0, ctl(1'b1, mode, 1'b0, 2'b00));
    wait_edges(8);
    chk(mode ? "R7 at compare" : "R8 at compare", count_o, 16'h0002);
    wait_edges(4);
    if (mode) chk("R7 match clears", count_o, 16'h0000);
    else      chk("R8 match ignored", count_o, 16'h0003);
    rd(1'b0, v); chk("R7 R8 no pending", v[2], 1'b0);
    cmp_val_i = 16'h0000;
  endtask

  task automatic t_coincide();
    logic [15:0] v;
    do_reset();
    cmp_val_i = 16'h0002;
    wr(1'b0, ctl(1'b1, 1'b1, 1'b0, 2'b00));
    wait_edges(11);
    chk("R9 before match", count_o, 16'h0002);
    wr(1'b0, ctl(1'b1, 1'b1, 1'b1, 2'b00));
    chk("R9 compare clear", count_o, 16'h0000);
    rd(1'b0, v); chk("R9 bit survives", v[2], 1'b1);
    wait_edges(1);
    rd(1'b0, v); chk("R9 released next clear", v[2], 1'b0);
    wait_edges(4); chk("R9 counting again", count_o, 16'h0001);
    // back-to-back requests
    wr(1'b0, ctl(1'b1, 1'b1, 1'b1, 2'b00));
    wr(1'b0, ctl(1'b1, 1'b1, 1'b1, 2'b00));
    rd(1'b0, v); chk("R9 repeat request kept", v[2], 1'b1);
    wait_edges(1);
    rd(1'b0, v); chk("R9 repeat request released", v[2], 1'b0);
    cmp_val_i = 16'h0000;
  endtask

  task automatic t_div_change();
    logic [15:0] v;
    do_reset();
    wr(1'b0, ctl(1'b1, 1'b0, 1'b0, 2'b00));
    wait_edges(2);
    wr(1'b0, ctl(1'b1, 1'b0, 1'b0, 2'b01));
    rd(1'b0, v); chk("R11 div field", v, 16'h0011);
    wait_edges(15); chk("R10 restarted, no step yet", count_o, 16'h0000);
    wait_edges(1);  chk("R10 step after full period", count_o, 16'h0001);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_div(2'b00, 4);
    t_div(2'b01, 16);
    t_div(2'b10, 32);
    t_div(2'b11, 64);
    t_wrap();
    t_stopped();
    t_clear_run();
    t_compare(1'b1);
    t_compare(1'b0);
    t_coincide();
    t_div_change();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule